// File: doc/BRIEF.md
# Interrupt Source Controller

This block holds the per-source state of an interrupt source layer and turns source activity into offers for a downstream presentation layer. Each offer carries a destination server, a global source number and an 8-bit priority. Every source has a configurable server and priority, and four status flags. A parameter fixes each source as either level or message type. The presentation layer sends commands back to the block: reject, end-of-interrupt (EOI) and resend. Configuration writes and reads also pass through the same single command port.

Global source numbers are the local index plus a fixed base of 16. A resend command starts a sequential sweep that visits the sources in ascending order, one source per cycle. The sweep replays anything that was rejected or that is still asserted and unsent. Commands that arrive while the sweep runs take precedence, and the sweep waits for them.

Top module: `irq_src_ctrl`

## Requirements
- R1: Command codes are NOP=0, EVENT=1, REJECT=2, EOI=3, CFG_WR=4, CFG_RD=5 and RESEND=6. A command whose number lies outside [16, 16+NUM_SRC) changes no source and produces no offer.
- R2: A message-type EVENT with value 1 sets the source's masked-pending flag if the source's priority is 0xFF. Otherwise it produces an offer of {server, number, priority}. A value of 0 is ignored.
- R3: A level-type EVENT copies its value into the source's asserted flag. The source is then offered, and its sent flag is set, only when its priority is not 0xFF, it is asserted and it is not already sent.
- R4: REJECT sets the rejected flag and clears the sent flag of the named source, for either type, and produces no offer.
- R5: EOI clears the sent flag of a level source. It has no effect on a message source.
- R6: An accepted CFG_WR stores the server and priority. A message source that is masked-pending and whose new priority is not 0xFF then clears that flag and is offered. A level source then applies the R3 offer rule.
- R7: CFG_WR answers with code 0xFD (-3) and stores nothing when the number is invalid, the server is at or above NUM_SRV, or the 9-bit priority exceeds 0xFF. An accepted write answers with code 0x00.
- R8: CFG_RD answers with code 0x00 and the source's server and priority. For an invalid number it answers with code 0xFD and zero data.
- R9: RESEND visits sources 0 to NUM_SRC-1 in order, one per cycle. A level source applies the R3 rule. A message source with rejected set has rejected cleared and is offered if its priority is not 0xFF.
- R10: In any cycle with a command present, the sweep does not advance. The command's own offer uses the offer port in that cycle.
- R11: Reset sets every server to 0, every priority to 0xFF and every flag to clear. Each source keeps its level or message type.
- R12: Every offer and every response is a single-cycle registered pulse. No offer ever carries priority 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Command code (R1) |
| cmd_num_i | input | NUM_W | Global source number |
| cmd_val_i | input | 1 | Event value |
| cmd_srv_i | input | SRV_W | Server for a configuration write |
| cmd_pri_i | input | 9 | Priority for a configuration write (bit 8 marks out of range) |
| ofr_valid_o | output | 1 | Offer pulse |
| ofr_num_o | output | NUM_W | Offered global source number |
| ofr_srv_o | output | SRV_W | Offered destination server |
| ofr_pri_o | output | 8 | Offered priority |
| rsp_valid_o | output | 1 | Configuration response pulse |
| rsp_code_o | output | 8 | 0x00 success, 0xFD refused |
| rsp_srv_o | output | SRV_W | Server returned by a read |
| rsp_pri_o | output | 8 | Priority returned by a read |
| sweep_busy_o | output | 1 | Resend sweep in progress |

## Verification
A command presented before clock edge k has its offer and its response visible right after edge k. The bench therefore drives on the falling edge and samples the outputs on the following falling edge.

During a sweep, source i is examined on edge k+1+i, where k is the edge that accepted the resend, with one edge added for each stalling command. The sweep checks record the sample index at which each offer appears and compare it with that count. The stall case places an event at sample 1 and expects the sweep's first offer one sample later than it would otherwise appear.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_EVENT  = 3'd1,
    OP_REJECT = 3'd2,
    OP_EOI    = 3'd3,
    OP_CFG_WR = 3'd4,
    OP_CFG_RD = 3'd5,
    OP_RESEND = 3'd6
  } isc_op_e;

  // per-source flag positions
  localparam int FLG_ASSERTED = 0;
  localparam int FLG_SENT     = 1;
  localparam int FLG_REJECTED = 2;
  localparam int FLG_MPEND    = 3;
  localparam int FLG_W        = 4;

  localparam logic [7:0] PRI_MASKED = 8'hFF;
  localparam logic [7:0] RSP_OK     = 8'h00;
  localparam logic [7:0] RSP_BADARG = 8'hFD;

endpackage

// File: rtl/irq_src_decode.sv
module irq_src_decode #(
  parameter int NUM_SRC = 8,
  parameter int NUM_W   = 12,
  parameter int BASE    = 16,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_W-1:0] num_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             hit_o
);
  localparam logic [NUM_W:0] LO = (NUM_W+1)'(BASE);
  localparam logic [NUM_W:0] HI = (NUM_W+1)'(BASE + NUM_SRC);

  assign hit_o = ({1'b0, num_i} >= LO) && ({1'b0, num_i} < HI);
  assign idx_o = IDX_W'(num_i - NUM_W'(BASE));
endmodule

// File: rtl/irq_src_sweep.sv
module irq_src_sweep #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stall_i,
  output logic             busy_o,
  output logic             step_o,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

  assign step_o = busy_o && !stall_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      ptr_o  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      ptr_o  <= '0;
    end else if (step_o) begin
      if (ptr_o == LAST) begin
        busy_o <= 1'b0;
        ptr_o  <= '0;
      end else begin
        ptr_o <= ptr_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int                 NUM_SRC   = 8,
  parameter int                 NUM_SRV   = 4,
  parameter int                 SRV_W     = 4,
  parameter int                 NUM_W     = 12,
  parameter int                 BASE      = 16,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP = 'hF0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [NUM_W-1:0] cmd_num_i,
  input  logic             cmd_val_i,
  input  logic [SRV_W-1:0] cmd_srv_i,
  input  logic [8:0]       cmd_pri_i,
  output logic             ofr_valid_o,
  output logic [NUM_W-1:0] ofr_num_o,
  output logic [SRV_W-1:0] ofr_srv_o,
  output logic [7:0]       ofr_pri_o,
  output logic             rsp_valid_o,
  output logic [7:0]       rsp_code_o,
  output logic [SRV_W-1:0] rsp_srv_o,
  output logic [7:0]       rsp_pri_o,
  output logic             sweep_busy_o
);
  localparam int              IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [SRV_W:0]  SRV_LIM = (SRV_W+1)'(NUM_SRV);

  isc_op_e op;
  assign op = isc_op_e'(cmd_op_i);

  logic [IDX_W-1:0] cidx, sw_ptr, sel_idx;
  logic             hit, sw_step;

  irq_src_decode #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .BASE(BASE), .IDX_W(IDX_W)) u_dec (
    .num_i(cmd_num_i), .idx_o(cidx), .hit_o(hit)
  );

  irq_src_sweep #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_sweep (
    .clk(clk), .rst(rst),
    .start_i(cmd_valid_i && op == OP_RESEND),
    .stall_i(cmd_valid_i),
    .busy_o(sweep_busy_o), .step_o(sw_step), .ptr_o(sw_ptr)
  );

  logic [SRV_W-1:0] srv_q [NUM_SRC];
  logic [7:0]       pri_q [NUM_SRC];
  logic [FLG_W-1:0] flg_q [NUM_SRC];

  logic [SRV_W-1:0] cur_srv, nxt_srv;
  logic [7:0]       cur_pri, nxt_pri;
  logic [FLG_W-1:0] cur_flg, nxt_flg;
  logic             is_lvl, upd_en, offer, cfg_ok;

  assign sel_idx = cmd_valid_i ? cidx : sw_ptr;
  assign cur_srv = srv_q[sel_idx];
  assign cur_pri = pri_q[sel_idx];
  assign cur_flg = flg_q[sel_idx];
  assign is_lvl  = LEVEL_MAP[sel_idx];
  assign cfg_ok  = hit && ({1'b0, cmd_srv_i} < SRV_LIM) && !cmd_pri_i[8];

  function automatic logic lvl_ready(input logic [FLG_W-1:0] f, input logic [7:0] p);
    return (p != PRI_MASKED) && f[FLG_ASSERTED] && !f[FLG_SENT];
  endfunction

  always_comb begin
    upd_en  = 1'b0;
    offer   = 1'b0;
    nxt_srv = cur_srv;
    nxt_pri = cur_pri;
    nxt_flg = cur_flg;
    if (cmd_valid_i) begin
      if (hit) begin
        unique case (op)
          OP_EVENT: begin
            if (is_lvl) begin
              upd_en = 1'b1;
              nxt_flg[FLG_ASSERTED] = cmd_val_i;
              if (lvl_ready(nxt_flg, cur_pri)) begin
                nxt_flg[FLG_SENT] = 1'b1;
                offer = 1'b1;
              end
            end else if (cmd_val_i) begin
              upd_en = 1'b1;
              if (cur_pri == PRI_MASKED) nxt_flg[FLG_MPEND] = 1'b1;
              else                       offer = 1'b1;
            end
          end
          OP_REJECT: begin
            upd_en = 1'b1;
            nxt_flg[FLG_REJECTED] = 1'b1;
            nxt_flg[FLG_SENT]     = 1'b0;
          end
          OP_EOI: begin
            if (is_lvl) begin
              upd_en = 1'b1;
              nxt_flg[FLG_SENT] = 1'b0;
            end
          end
          OP_CFG_WR: begin
            if (cfg_ok) begin
              upd_en  = 1'b1;
              nxt_srv = cmd_srv_i;
              nxt_pri = cmd_pri_i[7:0];
              if (is_lvl) begin
                if (lvl_ready(cur_flg, nxt_pri)) begin
                  nxt_flg[FLG_SENT] = 1'b1;
                  offer = 1'b1;
                end
              end else if (cur_flg[FLG_MPEND] && nxt_pri != PRI_MASKED) begin
                nxt_flg[FLG_MPEND] = 1'b0;
                offer = 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end else if (sw_step) begin
      if (is_lvl) begin
        if (lvl_ready(cur_flg, cur_pri)) begin
          upd_en = 1'b1;
          nxt_flg[FLG_SENT] = 1'b1;
          offer = 1'b1;
        end
      end else if (cur_flg[FLG_REJECTED]) begin
        upd_en = 1'b1;
        nxt_flg[FLG_REJECTED] = 1'b0;
        offer = (cur_pri != PRI_MASKED);
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        srv_q[g] <= '0;
        pri_q[g] <= PRI_MASKED;
        flg_q[g] <= '0;
      end else if (upd_en && sel_idx == IDX_W'(g)) begin
        srv_q[g] <= nxt_srv;
        pri_q[g] <= nxt_pri;
        flg_q[g] <= nxt_flg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ofr_valid_o <= 1'b0;
      ofr_num_o   <= '0;
      ofr_srv_o   <= '0;
      ofr_pri_o   <= '0;
      rsp_valid_o <= 1'b0;
      rsp_code_o  <= RSP_OK;
      rsp_srv_o   <= '0;
      rsp_pri_o   <= '0;
    end else begin
      ofr_valid_o <= offer;
      ofr_num_o   <= NUM_W'(sel_idx) + NUM_W'(BASE);
      ofr_srv_o   <= nxt_srv;
      ofr_pri_o   <= nxt_pri;
      rsp_valid_o <= cmd_valid_i && (op == OP_CFG_WR || op == OP_CFG_RD);
      rsp_code_o  <= ((op == OP_CFG_WR) ? cfg_ok : hit) ? RSP_OK : RSP_BADARG;
      rsp_srv_o   <= (op == OP_CFG_RD && hit) ? cur_srv : '0;
      rsp_pri_o   <= (op == OP_CFG_RD && hit) ? cur_pri : '0;
    end
  end
endmodule

// File: rtl/irq_src_ctrl_chk.sv
module irq_src_ctrl_chk #(
  parameter int NUM_SRC = 8,
  parameter int NUM_SRV = 4,
  parameter int SRV_W   = 4,
  parameter int NUM_W   = 12,
  parameter int BASE    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid_i,
  input logic [2:0]       cmd_op_i,
  input logic             ofr_valid_o,
  input logic [NUM_W-1:0] ofr_num_o,
  input logic [SRV_W-1:0] ofr_srv_o,
  input logic [7:0]       ofr_pri_o,
  input logic             rsp_valid_o,
  input logic [7:0]       rsp_code_o,
  input logic             sweep_busy_o
);
  p_offer_range_r1: assert property (@(posedge clk) disable iff (rst)
    ofr_valid_o |-> (int'(ofr_num_o) >= BASE && int'(ofr_num_o) < BASE + NUM_SRC));

  p_no_offer_after_rej_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && (cmd_op_i == 3'd2 || cmd_op_i == 3'd3 || cmd_op_i == 3'd5)) |=> !ofr_valid_o);

  p_offer_server_r7: assert property (@(posedge clk) disable iff (rst)
    ofr_valid_o |-> (int'(ofr_srv_o) < NUM_SRV));

  p_rsp_code_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> (rsp_code_o == 8'h00 || rsp_code_o == 8'hFD));

  p_rsp_needs_cmd_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> $past(cmd_valid_i && (cmd_op_i == 3'd4 || cmd_op_i == 3'd5)));

  p_busy_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (sweep_busy_o && cmd_valid_i && cmd_op_i != 3'd6) |=> sweep_busy_o);

  p_offer_unmasked_r12: assert property (@(posedge clk) disable iff (rst)
    ofr_valid_o |-> ofr_pri_o != 8'hFF);
endmodule

bind irq_src_ctrl irq_src_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .NUM_SRV(NUM_SRV), .SRV_W(SRV_W), .NUM_W(NUM_W), .BASE(BASE)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
  .ofr_valid_o(ofr_valid_o), .ofr_num_o(ofr_num_o), .ofr_srv_o(ofr_srv_o),
  .ofr_pri_o(ofr_pri_o), .rsp_valid_o(rsp_valid_o), .rsp_code_o(rsp_code_o),
  .sweep_busy_o(sweep_busy_o)
);

// File: tb/irq_src_ctrl_tb.sv
`timescale 1ns/1ps
module irq_src_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid_i = 1'b0;
  logic [2:0]  cmd_op_i = '0;
  logic [11:0] cmd_num_i = '0;
  logic        cmd_val_i = 1'b0;
  logic [3:0]  cmd_srv_i = '0;
  logic [8:0]  cmd_pri_i = '0;
  logic        ofr_valid_o, rsp_valid_o, sweep_busy_o;
  logic [11:0] ofr_num_o;
  logic [3:0]  ofr_srv_o, rsp_srv_o;
  logic [7:0]  ofr_pri_o, rsp_code_o, rsp_pri_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  irq_src_ctrl u_dut (
    .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_num_i(cmd_num_i), .cmd_val_i(cmd_val_i), .cmd_srv_i(cmd_srv_i),
    .cmd_pri_i(cmd_pri_i), .ofr_valid_o(ofr_valid_o), .ofr_num_o(ofr_num_o),
    .ofr_srv_o(ofr_srv_o), .ofr_pri_o(ofr_pri_o), .rsp_valid_o(rsp_valid_o),
    .rsp_code_o(rsp_code_o), .rsp_srv_o(rsp_srv_o), .rsp_pri_o(rsp_pri_o),
    .sweep_busy_o(sweep_busy_o)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [11:0] num;
    logic        val;
    logic [3:0]  srv;
    logic [8:0]  pri;
    logic        ev;
    logic [11:0] enm;
    logic [3:0]  esrv;
    logic [7:0]  epri;
    logic [3:0]  rq;
  } vec_t;

  // sources 16..19 message type, 20..23 level type
  localparam vec_t VEC [18] = '{
    '{3'd1, 12'd16, 1'b1, 4'd0, 9'd0,   1'b0, 12'd0,  4'd0, 8'd0, 4'd2},  // R2 masked fire
    '{3'd4, 12'd16, 1'b0, 4'd2, 9'd5,   1'b1, 12'd16, 4'd2, 8'd5, 4'd6},  // R6 replay
    '{3'd1, 12'd16, 1'b0, 4'd0, 9'd0,   1'b0, 12'd0,  4'd0, 8'd0, 4'd2},  // R2 zero value
    '{3'd1, 12'd16, 1'b1, 4'd0, 9'd0,   1'b1, 12'd16, 4'd2, 8'd5, 4'd2},  // R2 direct
    '{3'd4, 12'd20, 1'b0, 4'd1, 9'd3,   1'b0, 12'd0,  4'd0, 8'd0, 4'd6},  // R6 level idle
    '{3'd1, 12'd20, 1'b1, 4'd0, 9'd0,   1'b1, 12'd20, 4'd1, 8'd3, 4'd3},  // R3 assert
    '{3'd1, 12'd20, 1'b1, 4'd0, 9'd0,   1'b0, 12'd0,  4'd0, 8'd0, 4'd3},  // R3 already sent
    '{3'd3, 12'd20, 1'b0, 4'd0, 9'd0,   1'b0, 12'd0,  4'd0, 8'd0, 4'd5},  // R5 eoi
    '{3'd1, 12'd20, 1'b1, 4'd0, 9'd0,   1'b1, 12'd20, 4'd1, 8'd3, 4'd3},  // R3 after eoi
    '{3'd2, 12'd20, 1'b0, 4'd0, 9'd0,   1'b0, 12'd0,  4'd0, 8'd0, 4'd4},  // R4 reject
    '{3'd4, 12'd20, 1'b0, 4'd1, 9'd3,   1'b1, 12'd20, 4'd1, 8'd3, 4'd6},  // R6 level rule
    '{3'd1, 12'd20, 1'b0, 4'd0, 9'd0,   1'b0, 12'd0,  4'd0, 8'd0, 4'd3},  // R3 deassert
    '{3'd3, 12'd20, 1'b0, 4'd0, 9'd0,   1'b0, 12'd0,  4'd0, 8'd0, 4'd5},  // R5
    '{3'd4, 12'd20, 1'b0, 4'd1, 9'd3,   1'b0, 12'd0,  4'd0, 8'd0, 4'd6},  // R6 not asserted
    '{3'd3, 12'd16, 1'b0, 4'd0, 9'd0,   1'b0, 12'd0,  4'd0, 8'd0, 4'd5},  // R5 message eoi
    '{3'd4, 12'd17, 1'b0, 4'd3, 9'd255, 1'b0, 12'd0,  4'd0, 8'd0, 4'd12}, // R12 masked
    '{3'd1, 12'd24, 1'b1, 4'd0, 9'd0,   1'b0, 12'd0,  4'd0, 8'd0, 4'd1},  // R1 above range
    '{3'd1, 12'd15, 1'b1, 4'd0, 9'd0,   1'b0, 12'd0,  4'd0, 8'd0, 4'd1}   // R1 below range
  };

  task automatic check(input string rq, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cmd(input int op, input int num, input int val, input int srv, input int pri);
    cmd_valid_i = 1'b1;
    cmd_op_i    = 3'(op);
    cmd_num_i   = 12'(num);
    cmd_val_i   = 1'(val);
    cmd_srv_i   = 4'(srv);
    cmd_pri_i   = 9'(pri);
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic exp_ofr(input string rq, input int v, input int num, input int srv, input int pri);
    check(rq, int'(ofr_valid_o), v);
    if (v != 0) begin
      check(rq, int'(ofr_num_o), num);
      check(rq, int'(ofr_srv_o), srv);
      check(rq, int'(ofr_pri_o), pri);
    end
  endtask

  task automatic exp_rsp(input string rq, input int code, input int srv, input int pri);
    check(rq, int'(rsp_valid_o), 1);
    check(rq, int'(rsp_code_o), code);
    check(rq, int'(rsp_srv_o), srv);
    check(rq, int'(rsp_pri_o), pri);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    int at [4];
    int nm [4];
    int sv [4];
    int pr [4];

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 idle offer", int'(ofr_valid_o), 0);
    check("R11 idle busy", int'(sweep_busy_o), 0);
    check("R11 idle rsp", int'(rsp_valid_o), 0);
    cmd(5, 18, 0, 0, 0);
    exp_rsp("R11 R8 read after reset", 8'h00, 0, 8'hFF);

    // table walk
    for (int i = 0; i < 18; i++) begin
      cmd(int'(VEC[i].op), int'(VEC[i].num), int'(VEC[i].val), int'(VEC[i].srv), int'(VEC[i].pri));
      exp_ofr($sformatf("R%0d vector %0d", VEC[i].rq, i), int'(VEC[i].ev),
              int'(VEC[i].enm), int'(VEC[i].esrv), int'(VEC[i].epri));
    end

    // R7 refused writes
    cmd(4, 15, 0, 1, 1);  exp_rsp("R7 num below", 8'hFD, 0, 0);
    cmd(4, 24, 0, 1, 1);  exp_rsp("R7 num above", 8'hFD, 0, 0);
    cmd(4, 23, 0, 4, 1);  exp_rsp("R7 server", 8'hFD, 0, 0);
    cmd(4, 23, 0, 1, 256); exp_rsp("R7 priority", 8'hFD, 0, 0);
    cmd(5, 23, 0, 0, 0);  exp_rsp("R7 nothing stored", 8'h00, 0, 8'hFF);
    cmd(4, 23, 0, 3, 255); exp_rsp("R7 boundary accepted", 8'h00, 0, 0);
    exp_ofr("R7 masked no offer", 0, 0, 0, 0);
    // R8 reads
    cmd(5, 24, 0, 0, 0);  exp_rsp("R8 invalid read", 8'hFD, 0, 0);
    cmd(5, 16, 0, 0, 0);  exp_rsp("R8 read", 8'h00, 2, 5);
    cmd(5, 23, 0, 0, 0);  exp_rsp("R8 read boundary", 8'h00, 3, 8'hFF);

    // sweep setup
    cmd(4, 17, 0, 1, 7);  exp_ofr("R6 no pending", 0, 0, 0, 0);
    cmd(2, 17, 0, 0, 0);
    cmd(2, 18, 0, 0, 0);
    cmd(4, 21, 0, 0, 2);  exp_ofr("R6 level idle", 0, 0, 0, 0);
    cmd(1, 21, 1, 0, 0);  exp_ofr("R3 level fire", 1, 21, 0, 2);
    cmd(2, 21, 0, 0, 0);

    // R9 sweep: source i offered at sample i+1
    cmd(6, 0, 0, 0, 0);
    check("R9 busy", int'(sweep_busy_o), 1);
    cnt = 0;
    for (int k = 0; k < 12; k++) begin
      if (ofr_valid_o && cnt < 4) begin
        at[cnt] = k; nm[cnt] = int'(ofr_num_o); sv[cnt] = int'(ofr_srv_o); pr[cnt] = int'(ofr_pri_o);
        cnt++;
      end
      @(negedge clk);
    end
    check("R9 offer count", cnt, 2);
    check("R9 first at", at[0], 2);
    check("R9 first num", nm[0], 17);
    check("R9 first srv", sv[0], 1);
    check("R9 first pri", pr[0], 7);
    check("R9 second at", at[1], 6);
    check("R9 second num", nm[1], 21);
    check("R9 second srv", sv[1], 0);
    check("R9 second pri", pr[1], 2);
    check("R9 done", int'(sweep_busy_o), 0);

    // R9 second sweep has nothing left to replay
    cmd(6, 0, 0, 0, 0);
    cnt = 0;
    for (int k = 0; k < 12; k++) begin
      if (ofr_valid_o) cnt++;
      @(negedge clk);
    end
    check("R9 empty sweep", cnt, 0);

    // R10 direct command stalls sweep
    cmd(2, 17, 0, 0, 0);
    cmd(6, 0, 0, 0, 0);
    cmd(1, 16, 1, 0, 0);
    exp_ofr("R10 direct wins", 1, 16, 2, 5);
    @(negedge clk);
    cnt = 0;
    for (int k = 2; k < 12; k++) begin
      if (ofr_valid_o && cnt < 4) begin
        at[cnt] = k; nm[cnt] = int'(ofr_num_o);
        cnt++;
      end
      @(negedge clk);
    end
    check("R10 stalled count", cnt, 1);
    check("R10 stalled at", at[0], 3);
    check("R10 stalled num", nm[0], 17);

    // R11 reset clears flags, keeps type
    cmd(4, 16, 0, 0, 255);
    cmd(1, 16, 1, 0, 0);
    exp_ofr("R11 masked pending", 0, 0, 0, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cmd(5, 20, 0, 0, 0);  exp_rsp("R11 level cleared", 8'h00, 0, 8'hFF);
    cmd(4, 16, 0, 0, 4);  exp_ofr("R11 pending cleared", 0, 0, 0, 0);
    cmd(4, 20, 0, 1, 3);
    cmd(1, 20, 1, 0, 0);  exp_ofr("R11 type kept", 1, 20, 1, 3);
    cmd(1, 20, 1, 0, 0);  exp_ofr("R11 type kept level", 0, 0, 0, 0);
    // R12 pulse width
    @(negedge clk);
    check("R12 single pulse", int'(ofr_valid_o), 0);
    check("R12 rsp pulse", int'(rsp_valid_o), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule